// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a single-channel 12-bit sampling converter with a serial output. For each sample request it drives the converter's active-low conversion-start strobe. It then waits on the converter's busy flag rather than on a fixed delay. After the conversion it generates a serial clock to shift in one 16-bit frame. The 12-bit sample is presented with a one-cycle valid pulse. Every interval is held as a cycle count derived from a system clock frequency parameter: strobe width, wake-up time, guard gap, serial clock rate and timeouts.

Two strobe disciplines are supported and chosen per conversion by a mode input.

- **Fast mode:** the strobe is a short low pulse and is back high long before the conversion ends.
- **Sleep mode:** the strobe stays low through the end of the conversion, which puts the converter to sleep. The next sample starts with a rising edge, a timed wake-up high period and then a falling edge.

A request that arrives while a cycle is running is held. It is served only after a guard gap has passed since the last serial clock edge of the read. If busy does not complete in time, a timeout error pulse is raised and the read is skipped.

Top module: `adc_conv_sequencer`

## Requirements
- R1: During and directly after reset the strobe output is high, the serial clock is low, and both the valid and error outputs are low.
- R2: In fast mode (mode input 0) the strobe falls, stays low for exactly STRB_CYC cycles (4 at defaults), and is high again when busy falls.
- R3: In sleep mode (mode input 1) the strobe is low when busy falls and stays low afterwards. When a cycle begins with the strobe low, the strobe first goes high for exactly WAKE_CYC cycles (600 at defaults) and then falls.
- R4: The read begins only after busy has been seen high and then low. No serial clock rising edge occurs while the conversion is still in progress.
- R5: A read is exactly 16 serial clock periods, with the clock idling low. Data is sampled on each falling edge, most significant bit first. The first 4 bits are ignored and the last 12 form the result, which is shown with a valid pulse of exactly one cycle.
- R6: The next strobe falling edge comes at least GUARD_CYC cycles (40 at defaults) after the last serial clock falling edge.
- R7: A request made while a cycle is in progress is kept and served after the guard gap. Several such requests collapse into a single extra conversion.
- R8: If busy has not completed within the timeout after the strobe falls (1000 cycles in fast mode, 2000 in sleep mode at defaults), a one-cycle error pulse is raised. For that cycle no serial clock is generated and no valid pulse is raised.
- R9: The mode is captured when a cycle starts. Changing the mode input while idle does not move the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Sample request, one or more cycles high |
| sleep_mode_i | input | 1 | 0 = fast pulsed strobe, 1 = sleep-after-conversion strobe |
| busy_i | input | 1 | Converter busy flag (asynchronous, synchronised inside) |
| sdata_i | input | 1 | Converter serial data line |
| convst_o | output | 1 | Active-low conversion-start strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | DATA_BITS | Last recovered sample |
| result_valid_o | output | 1 | One-cycle pulse when result_o is updated |
| timeout_err_o | output | 1 | One-cycle pulse when busy did not complete in time |

## Verification
The assertions assume the following about the inputs:

- The busy flag rises shortly after a strobe falling edge and falls once per conversion.
- The serial data line changes only just after a serial clock rising edge.
- The mode input is steady while a cycle is running.

The bench models the converter to match. Its busy flag and data line are driven in response to the block's own strobe and clock edges, and the mode is changed only from the sequence tasks between cycles. An optional stuck mode holds busy low to reach the timeout.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PULSE,
        ST_WAIT,
        ST_READ,
        ST_GUARD
    } seq_state_e;

    // Converts nanoseconds to whole clock cycles, rounding up, never zero.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold the values 0..maxv.
    function automatic int unsigned cnt_width(int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/adcs_sync.sv
module adcs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/adcs_req_hold.sv
module adcs_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic take_i,
    output logic go_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)         pend_q <= 1'b0;
        else if (take_i) pend_q <= 1'b0;
        else if (req_i)  pend_q <= 1'b1;
    end

    assign go_o = req_i | pend_q;
endmodule

// File: rtl/adcs_strobe_fsm.sv
module adcs_strobe_fsm
    import adcs_pkg::*;
#(
    parameter int unsigned STRB_CYC     = 4,
    parameter int unsigned WAKE_CYC     = 600,
    parameter int unsigned GUARD_CYC    = 40,
    parameter int unsigned TO_FAST_CYC  = 1000,
    parameter int unsigned TO_SLEEP_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic sleep_i,
    input  logic busy_i,
    input  logic rd_done_i,
    output logic take_o,
    output logic convst_o,
    output logic rd_start_o,
    output logic err_o
);
    localparam int unsigned CMAX = max2(max2(STRB_CYC, WAKE_CYC), GUARD_CYC);
    localparam int unsigned CW   = cnt_width(CMAX);
    localparam int unsigned TW   = cnt_width(max2(TO_FAST_CYC, TO_SLEEP_CYC));
    localparam logic [CW-1:0] STRB_LD  = CW'(STRB_CYC - 1);
    localparam logic [CW-1:0] WAKE_LD  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] GUARD_LD = CW'(GUARD_CYC - 1);
    localparam logic [TW-1:0] TO_F_END = TW'(TO_FAST_CYC - 1);
    localparam logic [TW-1:0] TO_S_END = TW'(TO_SLEEP_CYC - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [TW-1:0] to_cnt;
    logic          seen, cur_sleep, convst_q, err_q, rd_start_q;
    logic [TW-1:0] to_end;

    assign to_end = cur_sleep ? TO_S_END : TO_F_END;
    assign take_o = (state == ST_IDLE) && go_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            to_cnt     <= '0;
            seen       <= 1'b0;
            cur_sleep  <= 1'b0;
            convst_q   <= 1'b1;
            err_q      <= 1'b0;
            rd_start_q <= 1'b0;
        end else begin
            err_q      <= 1'b0;
            rd_start_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go_i) begin
                        cur_sleep <= sleep_i;
                        if (convst_q) begin
                            convst_q <= 1'b0;
                            cnt      <= STRB_LD;
                            to_cnt   <= '0;
                            seen     <= 1'b0;
                            state    <= ST_PULSE;
                        end else begin
                            convst_q <= 1'b1;
                            cnt      <= WAKE_LD;
                            state    <= ST_WAKE;
                        end
                    end
                end
                ST_WAKE: begin
                    if (cnt == '0) begin
                        convst_q <= 1'b0;
                        cnt      <= STRB_LD;
                        to_cnt   <= '0;
                        seen     <= 1'b0;
                        state    <= ST_PULSE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PULSE: begin
                    to_cnt <= to_cnt + 1'b1;
                    if (busy_i) seen <= 1'b1;
                    if (cnt == '0) begin
                        convst_q <= ~cur_sleep;
                        state    <= ST_WAIT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WAIT: begin
                    to_cnt <= to_cnt + 1'b1;
                    if (busy_i) seen <= 1'b1;
                    if (seen && !busy_i) begin
                        rd_start_q <= 1'b1;
                        state      <= ST_READ;
                    end else if (to_cnt == to_end) begin
                        err_q <= 1'b1;
                        cnt   <= GUARD_LD;
                        state <= ST_GUARD;
                    end
                end
                ST_READ: begin
                    if (rd_done_i) begin
                        cnt   <= GUARD_LD;
                        state <= ST_GUARD;
                    end
                end
                ST_GUARD: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign convst_o   = convst_q;
    assign rd_start_o = rd_start_q;
    assign err_o      = err_q;

    AST_IDLE_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !go_i) |=> $stable(convst_q)); // R9
    AST_FAST_STROBE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !cur_sleep) |-> convst_q); // R2
    AST_SLEEP_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && cur_sleep) |-> !convst_q); // R3
    AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_start_q |-> (seen && !busy_i) || $past(seen)); // R4
endmodule

// File: rtl/adcs_serial_rx.sv
module adcs_serial_rx
    import adcs_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned DATA_BITS  = 12,
    parameter int unsigned HALF_CYC   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 sdata_i,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o
);
    localparam int unsigned BW = cnt_width(FRAME_BITS - 1);
    localparam int unsigned HW = cnt_width(HALF_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [HW-1:0] HALF_LD  = HW'(HALF_CYC - 1);

    logic                 active, sclk_q, valid_q;
    logic [BW-1:0]        bit_cnt;
    logic [HW-1:0]        ph_cnt;
    logic [DATA_BITS-1:0] shreg, data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sclk_q  <= 1'b0;
            valid_q <= 1'b0;
            bit_cnt <= '0;
            ph_cnt  <= '0;
            shreg   <= '0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            if (!active) begin
                if (start_i) begin
                    active  <= 1'b1;
                    sclk_q  <= 1'b1;
                    ph_cnt  <= HALF_LD;
                    bit_cnt <= '0;
                end
            end else if (ph_cnt != '0) begin
                ph_cnt <= ph_cnt - 1'b1;
            end else if (sclk_q) begin
                // falling edge: capture one bit, MSB first
                sclk_q <= 1'b0;
                ph_cnt <= HALF_LD;
                shreg  <= {shreg[DATA_BITS-2:0], sdata_i};
                if (bit_cnt == LAST_BIT) begin
                    active  <= 1'b0;
                    data_q  <= {shreg[DATA_BITS-2:0], sdata_i};
                    valid_q <= 1'b1;
                end
            end else begin
                sclk_q  <= 1'b1;
                ph_cnt  <= HALF_LD;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign sclk_o  = sclk_q;
    assign data_o  = data_q;
    assign valid_o = valid_q;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R5
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        sclk_q |-> active); // R5
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !active); // R4
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adcs_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned STRB_NS     = 40,
    parameter int unsigned WAKE_NS     = 6000,
    parameter int unsigned GUARD_NS    = 400,
    parameter int unsigned SCLK_NS     = 100,
    parameter int unsigned TO_FAST_NS  = 10000,
    parameter int unsigned TO_SLEEP_NS = 20000,
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned DATA_BITS   = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic                 sleep_mode_i,
    input  logic                 busy_i,
    input  logic                 sdata_i,
    output logic                 convst_o,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] result_o,
    output logic                 result_valid_o,
    output logic                 timeout_err_o
);
    localparam int unsigned STRB_CYC     = ns_to_cyc(STRB_NS, CLK_MHZ);
    localparam int unsigned WAKE_CYC     = ns_to_cyc(WAKE_NS, CLK_MHZ);
    localparam int unsigned GUARD_CYC    = ns_to_cyc(GUARD_NS, CLK_MHZ);
    localparam int unsigned TO_FAST_CYC  = ns_to_cyc(TO_FAST_NS, CLK_MHZ);
    localparam int unsigned TO_SLEEP_CYC = ns_to_cyc(TO_SLEEP_NS, CLK_MHZ);
    localparam int unsigned HALF_CYC     = max2(1, ns_to_cyc(SCLK_NS, CLK_MHZ) / 2);

    logic busy_s, go, take, rd_start, rd_done;

    adcs_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk (clk),
        .rst (rst),
        .d_i (busy_i),
        .q_o (busy_s)
    );

    adcs_req_hold u_req (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .take_i (take),
        .go_o   (go)
    );

    adcs_strobe_fsm #(
        .STRB_CYC     (STRB_CYC),
        .WAKE_CYC     (WAKE_CYC),
        .GUARD_CYC    (GUARD_CYC),
        .TO_FAST_CYC  (TO_FAST_CYC),
        .TO_SLEEP_CYC (TO_SLEEP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go),
        .sleep_i    (sleep_mode_i),
        .busy_i     (busy_s),
        .rd_done_i  (rd_done),
        .take_o     (take),
        .convst_o   (convst_o),
        .rd_start_o (rd_start),
        .err_o      (timeout_err_o)
    );

    adcs_serial_rx #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_BITS  (DATA_BITS),
        .HALF_CYC   (HALF_CYC)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .start_i (rd_start),
        .sdata_i (sdata_i),
        .sclk_o  (sclk_o),
        .data_o  (result_o),
        .valid_o (rd_done)
    );

    assign result_valid_o = rd_done;

    AST_ERR_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (rst)
        !(timeout_err_o && result_valid_o)); // R8
endmodule

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
    localparam int STRB_CYC  = 4;
    localparam int WAKE_CYC  = 600;
    localparam int GUARD_CYC = 40;
    localparam int TO_FAST   = 1000;
    localparam int TO_SLEEP  = 2000;
    localparam int CONV_CYC  = 800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic sleep_mode = 1'b0;
    logic busy = 1'b0;
    logic sdata = 1'b0;
    logic convst, sclk, valid, err;
    logic [11:0] result;

    always #5 clk = ~clk;

    adc_conv_sequencer dut (
        .clk (clk), .rst (rst), .req_i (req), .sleep_mode_i (sleep_mode),
        .busy_i (busy), .sdata_i (sdata), .convst_o (convst), .sclk_o (sclk),
        .result_o (result), .result_valid_o (valid), .timeout_err_o (err)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int cyc = 0, fall_cyc = 0, rise_cyc = -100000, sfall_cyc = 0;
    int conv_cnt = 0, sclk_rises = 0, n_conv = 0, exp_sample = 0;
    bit cv_prev = 1, sc_prev = 0, awake = 1, wake_pend = 0, have_sfall = 0, stuck = 0;
    logic [15:0] frame = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            cv_prev = 1; sc_prev = 0; conv_cnt = 0; awake = 1; wake_pend = 0;
            busy <= 1'b0;
        end else begin
            if (cv_prev && !convst) begin
                if (wake_pend) begin
                    chk(cyc - rise_cyc == WAKE_CYC, "R3 wake high time", cyc - rise_cyc, WAKE_CYC);
                    wake_pend = 0;
                end
                if (have_sfall)
                    chk(cyc - sfall_cyc >= GUARD_CYC, "R6 guard gap", cyc - sfall_cyc, GUARD_CYC);
                fall_cyc = cyc;
                sclk_rises = 0;
                if (!stuck) begin
                    busy <= 1'b1;
                    conv_cnt = CONV_CYC;
                    exp_sample = int'($urandom % 4096);
                    frame = {4'b0000, 12'(exp_sample)};
                    n_conv++;
                end
            end
            if (!cv_prev && convst) begin
                rise_cyc = cyc;
                if (!awake) begin wake_pend = 1; awake = 1; end
                if (conv_cnt > 0 && !sleep_mode)
                    chk(cyc - fall_cyc == STRB_CYC, "R2 pulse width", cyc - fall_cyc, STRB_CYC);
            end
            if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0) begin
                    busy <= 1'b0;
                    chk(convst == !sleep_mode, sleep_mode ? "R3 strobe low at end" : "R2 strobe high at end",
                        int'(convst), int'(!sleep_mode));
                    if (!convst) awake = 0;
                end
            end
            if (!sc_prev && sclk) begin
                if (sclk_rises == 0)
                    chk(conv_cnt == 0 && !busy, "R4 read after busy", conv_cnt, 0);
                if (sclk_rises < 16) sdata <= frame[15 - sclk_rises];
                sclk_rises++;
            end
            if (sc_prev && !sclk) begin
                sfall_cyc = cyc;
                have_sfall = 1;
            end
            cv_prev = convst;
            sc_prev = sclk;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic wait_event(output bit got_v, output bit got_e, output int lat);
        int n = 0;
        got_v = 0; got_e = 0; lat = 0;
        while (!got_v && !got_e && n < 6000) begin
            @(negedge clk);
            n++;
            if (valid) got_v = 1;
            if (err) begin got_e = 1; lat = cyc - fall_cyc; end
        end
    endtask

    task automatic check_sample(input string tag);
        bit v, e;
        int lat;
        wait_event(v, e, lat);
        chk(v && !e, {tag, " R5 valid seen"}, int'(v), 1);
        chk(result == 12'(exp_sample), {tag, " R5 result"}, int'(result), exp_sample);
        chk(sclk_rises == 16, {tag, " R5 clock count"}, sclk_rises, 16);
        @(negedge clk);
        chk(!valid, {tag, " R5 valid one cycle"}, int'(valid), 0);
    endtask

    task automatic run_sample(input bit sl, input string tag);
        sleep_mode = sl;
        pulse_req();
        check_sample(tag);
    endtask

    task automatic idle_toggle(input bit lvl);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            sleep_mode = ~sleep_mode;
            if (convst != lvl) begin
                chk(0, "R9 strobe moved while idle", int'(convst), int'(lvl));
                break;
            end
        end
        chk(convst == lvl && !sclk, "R9 idle strobe steady", int'(convst), int'(lvl));
    endtask

    task automatic run_timeout(input bit sl, input int exp_lat);
        bit v, e;
        int lat;
        stuck = 1;
        sleep_mode = sl;
        pulse_req();
        wait_event(v, e, lat);
        chk(e && !v, "R8 error pulse", int'(e), 1);
        chk(lat >= exp_lat - 2 && lat <= exp_lat + 1, "R8 timeout latency", lat, exp_lat);
        @(negedge clk);
        chk(!err, "R8 error one cycle", int'(err), 0);
        chk(sclk_rises == 0, "R8 no read", sclk_rises, 0);
        repeat (60) @(negedge clk);
        stuck = 0;
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int dummy;
        bit v, e;
        int lat, base;
        dummy = int'($urandom(32'h5EED));
        @(negedge clk);
        chk(convst && !sclk && !valid && !err, "R1 in reset", int'({convst, sclk, valid, err}), 8);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(convst == 1'b1, "R1 strobe high", int'(convst), 1);
        chk(!sclk && !valid && !err, "R1 outputs idle", int'({sclk, valid, err}), 0);

        run_sample(1'b0, "fast");
        repeat (20) @(negedge clk);
        idle_toggle(1'b1);
        sleep_mode = 1'b0;
        run_sample(1'b1, "sleep from high");
        repeat (20) @(negedge clk);
        chk(!convst, "R3 stays low after read", int'(convst), 0);
        run_sample(1'b1, "sleep from low");
        repeat (20) @(negedge clk);
        idle_toggle(1'b0);
        run_sample(1'b0, "fast after sleep");
        repeat (50) @(negedge clk);

        // R7: two requests during one cycle produce exactly one extra conversion
        base = n_conv;
        sleep_mode = 1'b0;
        pulse_req();
        repeat (150) @(negedge clk);
        pulse_req();
        repeat (150) @(negedge clk);
        pulse_req();
        check_sample("R7 first");
        check_sample("R7 held");
        wait_event(v, e, lat);
        chk(!v && !e, "R7 no third cycle", int'(v), 0);
        chk(n_conv - base == 2, "R7 conversion count", n_conv - base, 2);

        run_timeout(1'b0, TO_FAST);
        run_timeout(1'b1, TO_SLEEP);
        run_sample(1'b0, "R8 recovery");

        for (int k = 0; k < 25; k++) begin
            bit sl;
            bit extra;
            sl = 1'($urandom % 2);
            extra = (($urandom % 4) == 0);
            sleep_mode = sl;
            pulse_req();
            if (extra) begin
                repeat (100 + int'($urandom % 300)) @(negedge clk);
                pulse_req();
            end
            check_sample("random");
            if (extra) check_sample("random R7 held");
            repeat (int'($urandom % 100)) @(negedge clk);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule